// File: doc/BRIEF.md
# Shared-Bus Packet Buffer DMA

This block puts two DMA engines onto one local buffer-memory bus. The packet engine moves frame bytes between the network FIFO and buffer memory. On transmit it fetches from memory into the FIFO, and on receive it drains the FIFO into memory. It always works in fixed bursts. When the MAC reports a collision on a transmit frame, the packet engine rewinds to the frame's start and fetches it again without any help from the host. After the retry limit is spent it drops the frame and raises an excessive-collision flag.

The host engine is a slave DMA. A host processor or host DMA reads or writes one datum at a time through a bidirectional data port, using a ready/acknowledge handshake. The block supplies only the buffer-side address. The two engines take turns on the memory bus, one transfer per cycle. In fused mode the host engine stops moving data, and its address register becomes the static upper half of a 32-bit address for the packet engine. The data path is 8 or 16 bits wide. Addresses are byte addresses, and in 16-bit mode they step by two.

Top module: `pktbuf_dma`

## Requirements
- R1: After reset, mem_en, fifo_push, fifo_pop, host_rdy, loc_done, rem_done and exc_col are all low.
- R2: A packet-engine burst covers 8 bytes: 8 transfers in byte mode, 4 in word mode. A burst runs in consecutive cycles once begun, even if loc_ready drops. It is cut short only by the end of the count.
- R3: On transmit (loc_dir=0), each transfer reads memory at the current address and pushes that datum to the FIFO (fifo_push, fifo_wdata). On receive (loc_dir=1), each transfer pops the FIFO (fifo_pop) and writes fifo_rdata to memory. Addresses start at loc_addr and rise.
- R4: loc_len counts bytes. Exactly loc_len/step transfers take place, after which loc_done is high and no further FIFO traffic occurs.
- R5: word_mode=1 selects 16-bit transfers. Addresses advance by 2 and the count drops by 2 per transfer. word_mode=0 advances both by 1.
- R6: At a burst boundary a packet-engine request (active, count not zero, loc_ready high) wins the bus. The host engine moves at most one datum per cycle, and only in cycles the packet engine leaves idle.
- R7: A collision pulse on an active transmit frame restarts it from loc_addr with the full length. This happens even when the pulse falls mid-burst. Up to 15 restarts are made. The 16th collision abandons the frame: exc_col goes high, loc_done goes high, and fetching stops.
- R8: Host read (rem_dir=0): the engine fetches memory at rising addresses from rem_addr into a holding register. While that register is full, host_rdy is high and host_data carries the datum. host_ack releases it.
- R9: Host write (rem_dir=1): host_rdy is high while the holding register is empty. host_ack captures host_data, which is then written to memory at rising addresses from rem_addr.
- R10: rem_done rises once rem_len bytes have moved and the holding register is empty.
- R11: With combined=1, mem_addr[31:16] equals the last value loaded by rem_start, and the host engine makes no transfer (host_rdy low). With combined=0, mem_addr[31:16] is zero.
- R12: A collision pulse has no effect on a receive transfer. All data lands in memory and exc_col stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | 1: 16-bit transfers, 0: 8-bit transfers |
| combined | input | 1 | Fuse the two address registers into one 32-bit address |
| loc_start | input | 1 | Load and start the packet engine |
| loc_dir | input | 1 | 0 transmit (memory to FIFO), 1 receive (FIFO to memory) |
| loc_addr | input | 16 | Packet start byte address |
| loc_len | input | 16 | Packet length in bytes |
| loc_ready | input | 1 | FIFO can take or supply a full burst |
| collision | input | 1 | Transmit collision pulse from the MAC |
| loc_done | output | 1 | Packet engine finished or abandoned |
| exc_col | output | 1 | Retry limit exceeded, frame dropped |
| fifo_push | output | 1 | Write strobe into the FIFO |
| fifo_wdata | output | 16 | Data into the FIFO |
| fifo_pop | output | 1 | Read strobe from the FIFO |
| fifo_rdata | input | 16 | FIFO head data (shown ahead of the pop) |
| rem_start | input | 1 | Load the host engine (and the page register) |
| rem_dir | input | 1 | 0 host read, 1 host write |
| rem_addr | input | 16 | Host engine start address, or page in fused mode |
| rem_len | input | 16 | Host transfer length in bytes |
| host_rdy | output | 1 | Holding register ready for the host |
| host_ack | input | 1 | Host takes or supplies one datum |
| host_data | inout | 16 | Bidirectional host data port |
| rem_done | output | 1 | Host transfer complete |
| mem_en | output | 1 | Buffer memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Buffer memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, same cycle |

## Verification
The delicate overlap is a burst boundary where the packet engine and the host engine both want the bus in the same cycle. The bench provokes this by running a host read or write alongside a packet transfer while loc_ready toggles at random, so that both engines often request in the same boundary cycle. Every cycle, a bench model tracks burst position and remaining bytes. It flags a host transfer in any cycle where the packet engine was entitled to the bus, and it flags a broken burst. The data in the FIFO stream, in the host stream and in memory is compared against what each engine should have moved.

// File: rtl/pktbuf_dma.sv
module pktbuf_dma #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int BURST_BYTES = 8,
  parameter int MAX_RETRY   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic          combined,
  input  logic          loc_start,
  input  logic          loc_dir,
  input  logic [AW-1:0] loc_addr,
  input  logic [AW-1:0] loc_len,
  input  logic          loc_ready,
  input  logic          collision,
  output logic          loc_done,
  output logic          exc_col,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_pop,
  input  logic [DW-1:0] fifo_rdata,
  input  logic          rem_start,
  input  logic          rem_dir,
  input  logic [AW-1:0] rem_addr,
  input  logic [AW-1:0] rem_len,
  output logic          host_rdy,
  input  logic          host_ack,
  inout  wire  [DW-1:0] host_data,
  output logic          rem_done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [2*AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int BW = $clog2(BURST_BYTES);
  localparam int RW = $clog2(MAX_RETRY + 1);

  logic          loc_act, loc_dq, in_burst, tx_pkt;
  logic [AW-1:0] loc_base, loc_lenq, loc_ptr, loc_cnt;
  logic [BW-1:0] beat;
  logic [RW-1:0] retry;
  logic          rem_act, rem_dq, hold_full;
  logic [AW-1:0] rem_ptr, rem_cnt;
  logic [DW-1:0] hold;

  wire [AW-1:0] step     = word_mode ? AW'(2) : AW'(1);
  wire [BW:0]   beat_sum = {1'b0, beat} + (word_mode ? (BW+1)'(2) : (BW+1)'(1));
  wire          burst_end = (beat_sum == (BW+1)'(BURST_BYTES)) || (loc_cnt <= step);
  wire [AW-1:0] loc_cnt_nx = (loc_cnt <= step) ? '0 : loc_cnt - step;
  wire [AW-1:0] rem_cnt_nx = (rem_cnt <= step) ? '0 : rem_cnt - step;
  wire          col_hit  = collision && tx_pkt;

  wire loc_req  = loc_act && (loc_cnt != '0) && loc_ready;
  wire gnt_loc  = in_burst || loc_req;
  wire rem_busy = rem_act && !combined && ((rem_cnt != '0) || hold_full);
  wire rem_req  = rem_act && !combined &&
                  (rem_dq ? hold_full : (!hold_full && (rem_cnt != '0)));
  wire gnt_rem  = !gnt_loc && rem_req;

  assign mem_en     = gnt_loc || gnt_rem;
  assign mem_we     = gnt_loc ? loc_dq : (gnt_rem && rem_dq);
  assign mem_addr   = {combined ? rem_ptr : '0, gnt_loc ? loc_ptr : rem_ptr};
  assign mem_wdata  = gnt_loc ? fifo_rdata : hold;
  assign fifo_push  = gnt_loc && !loc_dq;
  assign fifo_pop   = gnt_loc && loc_dq;
  assign fifo_wdata = mem_rdata;
  assign loc_done   = loc_act && (loc_cnt == '0);
  assign host_rdy   = rem_busy && (rem_dq ? !hold_full : hold_full);
  assign host_data  = (rem_busy && !rem_dq && hold_full) ? hold : 'z;
  assign rem_done   = rem_act && (rem_cnt == '0) && !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_act <= 1'b0; loc_dq <= 1'b0; in_burst <= 1'b0; tx_pkt <= 1'b0;
      loc_base <= '0; loc_lenq <= '0; loc_ptr <= '0; loc_cnt <= '0;
      beat <= '0; retry <= '0; exc_col <= 1'b0;
    end else if (loc_start) begin
      loc_act <= 1'b1; loc_dq <= loc_dir; tx_pkt <= !loc_dir;
      loc_base <= loc_addr; loc_lenq <= loc_len;
      loc_ptr <= loc_addr; loc_cnt <= loc_len;
      in_burst <= 1'b0; beat <= '0; retry <= '0; exc_col <= 1'b0;
    end else if (col_hit) begin
      in_burst <= 1'b0; beat <= '0;
      if (retry == RW'(MAX_RETRY)) begin
        exc_col <= 1'b1; tx_pkt <= 1'b0; loc_cnt <= '0;
      end else begin
        retry <= retry + 1'b1; loc_ptr <= loc_base; loc_cnt <= loc_lenq;
      end
    end else if (gnt_loc) begin
      loc_ptr <= loc_ptr + step;
      loc_cnt <= loc_cnt_nx;
      if (burst_end) begin
        in_burst <= 1'b0; beat <= '0;
      end else begin
        in_burst <= 1'b1; beat <= beat_sum[BW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_act <= 1'b0; rem_dq <= 1'b0; hold_full <= 1'b0;
      rem_ptr <= '0; rem_cnt <= '0; hold <= '0;
    end else if (rem_start) begin
      rem_act <= !combined; rem_dq <= rem_dir; hold_full <= 1'b0;
      rem_ptr <= rem_addr; rem_cnt <= rem_len;
    end else if (gnt_rem) begin
      rem_ptr <= rem_ptr + step;
      rem_cnt <= rem_cnt_nx;
      if (rem_dq) hold_full <= 1'b0;
      else begin
        hold <= mem_rdata; hold_full <= 1'b1;
      end
    end else if (host_ack && host_rdy) begin
      if (rem_dq) begin
        hold <= host_data; hold_full <= 1'b1;
      end else hold_full <= 1'b0;
    end
  end

  p_burst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_loc && !burst_end && !loc_start && !col_hit |=> (fifo_push || fifo_pop));
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_loc && !burst_end && !loc_start && !col_hit |=>
      mem_addr[AW-1:0] == $past(loc_ptr + step));
  p_quiet_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loc_done |-> !(fifo_push || fifo_pop));
  p_remote_yield_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst |-> !(mem_en && !fifo_push && !fifo_pop));
  p_exc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_col && !loc_start |=> exc_col);
  p_abandon_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_col) |-> loc_done);
  p_combined_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    combined |-> !host_rdy);
endmodule

// File: tb/tb_pktbuf_dma.sv
module tb_pktbuf_dma;
  logic clk = 0, rst_n = 0;
  logic word_mode = 0, combined = 0;
  logic loc_start = 0, loc_dir = 0, loc_ready = 1, collision = 0;
  logic [15:0] loc_addr = 0, loc_len = 0, rem_addr = 0, rem_len = 0;
  logic rem_start = 0, rem_dir = 0, host_ack = 0, host_oe = 0;
  logic [15:0] host_drv = 0;
  wire  [15:0] host_data;
  logic loc_done, exc_col, fifo_push, fifo_pop, host_rdy, rem_done, mem_en, mem_we;
  logic [15:0] fifo_wdata, fifo_rdata, mem_wdata, mem_rdata;
  logic [31:0] mem_addr;

  pktbuf_dma dut (.clk(clk), .rst_n(rst_n), .word_mode(word_mode), .combined(combined),
    .loc_start(loc_start), .loc_dir(loc_dir), .loc_addr(loc_addr), .loc_len(loc_len),
    .loc_ready(loc_ready), .collision(collision), .loc_done(loc_done), .exc_col(exc_col),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop),
    .fifo_rdata(fifo_rdata), .rem_start(rem_start), .rem_dir(rem_dir),
    .rem_addr(rem_addr), .rem_len(rem_len), .host_rdy(host_rdy), .host_ack(host_ack),
    .host_data(host_data), .rem_done(rem_done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] mem [0:255];
  logic [15:0] pushed [0:1023];
  logic [15:0] got [0:255];
  logic [15:0] sent [0:255];
  int push_n = 0, pop_n = 0, got_n = 0, sent_n = 0;
  bit rand_rdy = 0, rd_mode = 0, tx_b = 0, comb_b = 0;
  logic [15:0] page_b = 0, exp_la = 0, exp_ra = 0, a_b = 0, l_b = 0;
  int rem_b = 0, bb = 0, ncol = 0;

  function automatic logic [15:0] rx_val(input int i);
    return 16'hA000 ^ 16'(i * 29);
  endfunction

  assign mem_rdata  = mem[mem_addr[7:0]];
  assign fifo_rdata = rx_val(pop_n);
  assign host_data  = host_oe ? host_drv : 'z;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    loc_ready = rand_rdy ? ($urandom % 4 != 0) : 1'b1;
    host_ack = 0; host_oe = 0;
    if (host_rdy && ($urandom % 3 != 0)) begin
      host_ack = 1;
      if (rd_mode) begin got[got_n] = host_data; got_n++; end
      else begin host_oe = 1; host_drv = 16'($urandom); sent[sent_n] = host_drv; sent_n++; end
    end
  end

  always @(negedge clk) begin
    int stp;
    bit lb;
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    stp = word_mode ? 2 : 1;
    lb = fifo_push || fifo_pop;
    if (rst_n) begin
      if (mem_en) chk(mem_addr[31:16] == (comb_b ? page_b : 16'h0), "R11 upper address", mem_addr[31:16], comb_b ? page_b : 16'h0);
      if (lb) begin
        chk(rem_b > 0, "R4 transfer beyond count", rem_b, 1);
        chk(mem_addr[15:0] == exp_la, "R3 local address", mem_addr[15:0], exp_la);
        exp_la += 16'(stp);
        rem_b = (rem_b > stp) ? rem_b - stp : 0;
        bb += stp;
        if (bb == 8 || rem_b == 0) bb = 0;
      end else if (rem_b > 0) begin
        chk(bb == 0, "R2 burst broken", bb, 0);
        chk(!(loc_ready && bb == 0), "R6 local not granted", loc_ready, 0);
      end
      if (mem_en && !lb) begin
        chk(mem_addr[15:0] == exp_ra, "R8 host engine address", mem_addr[15:0], exp_ra);
        chk(!comb_b, "R11 host move in fused mode", 1, 0);
        exp_ra += 16'(stp);
      end
      if (fifo_push) begin pushed[push_n] = fifo_wdata; push_n++; end
      if (mem_en && mem_we) mem[mem_addr[7:0]] = mem_wdata;
      if (fifo_pop) pop_n++;
      if (collision && tx_b) begin
        if (ncol == 15) begin rem_b = 0; bb = 0; tx_b = 0; end
        else begin ncol++; rem_b = l_b; bb = 0; exp_la = a_b; end
      end
    end
  end

  task automatic loc_go(input bit dir, input logic [15:0] a, input logic [15:0] l);
    @(posedge clk); #1;
    push_n = 0; pop_n = 0;
    loc_dir = dir; loc_addr = a; loc_len = l; loc_start = 1;
    @(posedge clk); #1;
    loc_start = 0;
    a_b = a; l_b = l; exp_la = a; rem_b = l; bb = 0; tx_b = !dir; ncol = 0;
  endtask

  task automatic rem_go(input bit dir, input logic [15:0] a, input logic [15:0] l);
    @(posedge clk); #1;
    got_n = 0; sent_n = 0; rd_mode = !dir;
    rem_dir = dir; rem_addr = a; rem_len = l; rem_start = 1;
    @(posedge clk); #1;
    rem_start = 0; exp_ra = a;
  endtask

  task automatic pulse_col();
    @(posedge clk); #1; collision = 1;
    @(posedge clk); #1; collision = 0;
  endtask

  task automatic wait_loc();
    for (int i = 0; i < 3000; i++) begin @(negedge clk); if (loc_done) break; end
  endtask

  task automatic wait_rem();
    for (int i = 0; i < 3000; i++) begin @(negedge clk); if (rem_done) break; end
  endtask

  initial begin
    int stp, n;
    logic [15:0] a, l;
    bit dir;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0131 + 16'h77);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!mem_en && !fifo_push && !fifo_pop && !host_rdy, "R1 bus idle", {mem_en, fifo_push, fifo_pop, host_rdy}, 0);
    chk(!loc_done && !rem_done && !exc_col, "R1 flags low", {loc_done, rem_done, exc_col}, 0);

    for (int it = 0; it < 8; it++) begin
      word_mode = it[0]; stp = word_mode ? 2 : 1;
      rand_rdy = it[1];
      dir = 1'($urandom % 2);
      a = 16'($urandom % 100);
      l = word_mode ? 16'(2 * (2 + $urandom % 16)) : 16'(1 + $urandom % 40);
      loc_go(dir, a, l);
      wait_loc();
      n = l / stp;
      chk(loc_done, "R4 done raised", loc_done, 1);
      if (!dir) begin
        chk(push_n == n, "R4 push count", push_n, n);
        for (int i = 0; i < n; i++)
          chk(pushed[i] == mem[8'(a + i * stp)], word_mode ? "R5 word fetch" : "R3 byte fetch", pushed[i], mem[8'(a + i * stp)]);
      end else begin
        chk(pop_n == n, "R4 pop count", pop_n, n);
        for (int i = 0; i < n; i++)
          chk(mem[8'(a + i * stp)] == rx_val(i), word_mode ? "R5 word store" : "R3 byte store", mem[8'(a + i * stp)], rx_val(i));
      end
    end

    word_mode = 1; rand_rdy = 1;
    rem_go(0, 16'd130, 16'd20);
    loc_go(0, 16'd10, 16'd24);
    wait_rem(); wait_loc();
    chk(rem_done, "R10 host read done", rem_done, 1);
    chk(got_n == 10, "R8 host read count", got_n, 10);
    for (int i = 0; i < 10; i++) chk(got[i] == mem[130 + 2 * i], "R8 host read data", got[i], mem[130 + 2 * i]);
    chk(push_n == 12, "R6 local completes beside host", push_n, 12);
    for (int i = 0; i < 12; i++) chk(pushed[i] == mem[10 + 2 * i], "R6 local data beside host", pushed[i], mem[10 + 2 * i]);

    word_mode = 0;
    rem_go(1, 16'd150, 16'd17);
    loc_go(1, 16'd40, 16'd19);
    wait_rem(); wait_loc();
    chk(rem_done, "R10 host write done", rem_done, 1);
    chk(sent_n == 17, "R9 host write count", sent_n, 17);
    for (int i = 0; i < 17; i++) chk(mem[150 + i] == sent[i], "R9 host write data", mem[150 + i], sent[i]);
    for (int i = 0; i < 19; i++) chk(mem[40 + i] == rx_val(i), "R6 local store beside host", mem[40 + i], rx_val(i));
    rand_rdy = 0;

    @(posedge clk); #1; combined = 1; comb_b = 1; page_b = 16'h5A5A;
    rem_go(0, 16'h5A5A, 16'd8);
    loc_go(0, 16'd5, 16'd12);
    wait_loc();
    chk(push_n == 12, "R11 fused local count", push_n, 12);
    chk(!rem_done && !host_rdy, "R11 host engine idle", {rem_done, host_rdy}, 0);
    @(posedge clk); #1; combined = 0; comb_b = 0;

    loc_go(0, 16'd20, 16'd12);
    for (int k = 0; k < 15; k++) begin
      if (k % 3 == 1) repeat (2 + $urandom % 6) @(posedge clk);
      else wait_loc();
      pulse_col();
    end
    wait_loc();
    chk(!exc_col, "R7 no drop within limit", exc_col, 0);
    for (int i = 0; i < 12; i++) chk(pushed[push_n - 12 + i] == mem[20 + i], "R7 refetch data", pushed[push_n - 12 + i], mem[20 + i]);
    pulse_col();
    @(negedge clk);
    chk(exc_col, "R7 excess flag", exc_col, 1);
    chk(loc_done, "R7 done on drop", loc_done, 1);
    n = push_n;
    repeat (20) @(negedge clk);
    chk(push_n == n, "R7 no fetch after drop", push_n, n);

    loc_go(1, 16'd60, 16'd16);
    repeat (5) @(posedge clk);
    pulse_col();
    wait_loc();
    chk(!exc_col, "R12 receive ignores collision flag", exc_col, 0);
    chk(pop_n == 16, "R12 receive pop count", pop_n, 16);
    for (int i = 0; i < 16; i++) chk(mem[60 + i] == rx_val(i), "R12 receive data", mem[60 + i], rx_val(i));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule